// File: doc/BRIEF.md
# Adaptive ADPCM Step Decoder

This block turns a stream of 4-bit adaptive differential codes into 12-bit signed audio samples. Every strobe carries one code. The block scales the code by a step size taken from a 49-entry table, adds the result to a running accumulator, and limits the sum to the signed sample range. It then moves its table pointer up or down according to the code's magnitude. Large codes push the step size up quickly, and small codes let it drift back down, so the decoder follows loud and quiet passages without any help from outside.

A sample source upstream gives one code per strobe at whatever rate it needs. A synchronous clear starts a new stream from silence with the smallest step. The decoded value stays on the output until the next strobe, and a one-cycle valid pulse marks each new value.

Top module: `adpcm_step_decoder`

## Requirements
- R1: In each code, bit 3 selects the direction: 0 adds the delta and 1 subtracts it. Bits 2:0 give the magnitude `mag` (0 to 7).
- R2: The delta added on a strobe is floor(((2*mag + 1) * step) / 8). `step` is the table entry picked by the current index.
- R3: The step table has 49 entries, indexed 0 to 48. Entry 0 is 16, entry 9 is 37 and entry 48 is 1552. The table holds the 49 values of the growth sequence listed in the bench.
- R4: After each strobe the index changes by -1 for magnitudes 0 to 3 and by +2, +5, +7 or +9 for magnitudes 4, 5, 6 or 7. The delta of a strobe uses the index as it stood before that strobe, so a new index affects only the next code.
- R5: When the index is 0 and the magnitude is 3 or less, the index stays at 0.
- R6: The index never goes above 48. An increase that would pass 48 stops at 48.
- R7: The accumulator is clamped after the delta is added. Sums above +2047 become +2047, and sums below -2048 become -2048.
- R8: `valid_o` is high for exactly the one cycle after a strobe, and the new sample is on `sample_o` in that cycle. Without a strobe, `sample_o` does not change.
- R9: `clr_i` sets the accumulator and the index to 0 at the next edge. It takes priority over a strobe in the same cycle, and in that case no valid pulse follows.
- R10: After reset, `sample_o` is 0, `valid_o` is 0 and the index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of the accumulator and the index |
| stb_i | input | 1 | Code strobe; one code is consumed per high cycle |
| code_i | input | 4 | Code: bit 3 is the direction, bits 2:0 are the magnitude |
| sample_o | output | SAMPLE_W (12) | Signed decoded sample |
| valid_o | output | 1 | One-cycle pulse that marks a new sample |

## Verification
The bench builds the decoder with its default 12-bit sample width. At that width the sum of a full-scale sample and the largest delta (2910) goes past the sample range, so saturation is reachable at both ends. A long run of magnitude-7 codes also walks the index up to its ceiling of 48 in six strobes, which makes the index ceiling and the largest step visible in the output. Directed sequences pin down the values where the index sits at 0 and where clear and strobe arrive together. A long random run, compared on every clock against a behavioural model, covers the mixed cases.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

    localparam int STEP_COUNT = 49;
    localparam int IDX_W      = $clog2(STEP_COUNT);
    localparam int STEP_W     = 11;
    localparam int MAG_W      = 3;
    localparam int PROD_W     = STEP_W + MAG_W + 1;
    localparam int DELTA_W    = PROD_W - 3;
    localparam int ADJ_W      = 5;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } code_t;

    // geometric step sizes, roughly 10% growth per entry
    function automatic step_t step_lookup(input idx_t i);
        case (i)
            6'd0:  return step_t'(16);
            6'd1:  return step_t'(17);
            6'd2:  return step_t'(19);
            6'd3:  return step_t'(21);
            6'd4:  return step_t'(23);
            6'd5:  return step_t'(25);
            6'd6:  return step_t'(28);
            6'd7:  return step_t'(31);
            6'd8:  return step_t'(34);
            6'd9:  return step_t'(37);
            6'd10: return step_t'(41);
            6'd11: return step_t'(45);
            6'd12: return step_t'(50);
            6'd13: return step_t'(55);
            6'd14: return step_t'(60);
            6'd15: return step_t'(66);
            6'd16: return step_t'(73);
            6'd17: return step_t'(80);
            6'd18: return step_t'(88);
            6'd19: return step_t'(97);
            6'd20: return step_t'(107);
            6'd21: return step_t'(118);
            6'd22: return step_t'(130);
            6'd23: return step_t'(143);
            6'd24: return step_t'(157);
            6'd25: return step_t'(173);
            6'd26: return step_t'(190);
            6'd27: return step_t'(209);
            6'd28: return step_t'(230);
            6'd29: return step_t'(253);
            6'd30: return step_t'(279);
            6'd31: return step_t'(307);
            6'd32: return step_t'(337);
            6'd33: return step_t'(371);
            6'd34: return step_t'(408);
            6'd35: return step_t'(449);
            6'd36: return step_t'(494);
            6'd37: return step_t'(544);
            6'd38: return step_t'(598);
            6'd39: return step_t'(658);
            6'd40: return step_t'(724);
            6'd41: return step_t'(796);
            6'd42: return step_t'(876);
            6'd43: return step_t'(963);
            6'd44: return step_t'(1060);
            6'd45: return step_t'(1166);
            6'd46: return step_t'(1282);
            6'd47: return step_t'(1411);
            default: return step_t'(1552);
        endcase
    endfunction

    function automatic logic signed [ADJ_W-1:0] index_adjust(input logic [MAG_W-1:0] m);
        case (m)
            3'd4:    return 5'sd2;
            3'd5:    return 5'sd5;
            3'd6:    return 5'sd7;
            3'd7:    return 5'sd9;
            default: return -5'sd1;
        endcase
    endfunction

endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom
    import adpcm_pkg::*;
(
    input  idx_t  idx_i,
    output step_t step_o
);
    assign step_o = step_lookup(idx_i);
endmodule

// File: rtl/adpcm_index_adapt.sv
module adpcm_index_adapt
    import adpcm_pkg::*;
(
    input  idx_t             idx_i,
    input  logic [MAG_W-1:0] mag_i,
    output idx_t             idx_o
);
    localparam int SW = IDX_W + 2;
    localparam logic signed [SW-1:0] TOP = SW'(STEP_COUNT - 1);

    logic signed [SW-1:0] sum;

    always_comb begin
        sum   = $signed({2'b00, idx_i}) + SW'(index_adjust(mag_i));
        idx_o = idx_i;
        if (idx_i != '0 || mag_i > 3'd3) begin
            if (sum < 0)
                idx_o = '0;
            else if (sum > TOP)
                idx_o = idx_t'(STEP_COUNT - 1);
            else
                idx_o = sum[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/adpcm_accum_sat.sv
module adpcm_accum_sat
    import adpcm_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic signed [SAMPLE_W-1:0] acc_i,
    input  code_t                      code_i,
    input  step_t                      step_i,
    output logic signed [SAMPLE_W-1:0] acc_o
);
    localparam int SUM_W = ((SAMPLE_W > DELTA_W) ? SAMPLE_W : DELTA_W) + 2;
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((2 ** (SAMPLE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(2 ** (SAMPLE_W - 1));

    logic [PROD_W-1:0]        prod;
    logic [DELTA_W-1:0]       dmag;
    logic signed [SUM_W-1:0]  dext;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        prod = PROD_W'({code_i.mag, 1'b1}) * PROD_W'(step_i);
        dmag = prod[PROD_W-1:3];
        dext = $signed(SUM_W'(dmag));
        sum  = SUM_W'(acc_i) + (code_i.neg ? -dext : dext);
        if (sum > MAXV)
            acc_o = MAXV[SAMPLE_W-1:0];
        else if (sum < MINV)
            acc_o = MINV[SAMPLE_W-1:0];
        else
            acc_o = sum[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/adpcm_step_decoder.sv
module adpcm_step_decoder
    import adpcm_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                stb_i,
    input  logic [3:0]          code_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                valid_o
);
    code_t                      code;
    step_t                      step;
    idx_t                       idx_q, idx_n;
    logic signed [SAMPLE_W-1:0] acc_q, acc_n;
    logic                       vld_q;

    assign code = code_t'(code_i);

    adpcm_step_rom u_rom (
        .idx_i  (idx_q),
        .step_o (step)
    );

    adpcm_index_adapt u_idx (
        .idx_i (idx_q),
        .mag_i (code.mag),
        .idx_o (idx_n)
    );

    adpcm_accum_sat #(.SAMPLE_W(SAMPLE_W)) u_acc (
        .acc_i  (acc_q),
        .code_i (code),
        .step_i (step),
        .acc_o  (acc_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
        end else if (clr_i) begin
            acc_q <= '0;
            idx_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= stb_i;
            if (stb_i) begin
                acc_q <= acc_n;
                idx_q <= idx_n;
            end
        end
    end

    assign sample_o = acc_q;
    assign valid_o  = vld_q;
endmodule

// File: rtl/adpcm_decoder_chk.sv
module adpcm_decoder_chk
    import adpcm_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                clr_i,
    input logic                stb_i,
    input logic [3:0]          code_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                valid_o,
    input idx_t                idx_q
);
    AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (rst) (stb_i && !clr_i) |=> valid_o); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !stb_i |=> !valid_o); // R8
    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!stb_i && !clr_i) |=> $stable(sample_o)); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) clr_i |=> (sample_o == '0 && !valid_o && idx_q == '0)); // R9
    AST_IDX_FLOOR_HOLD: assert property (@(posedge clk) disable iff (rst) (stb_i && !clr_i && idx_q == '0 && code_i[2:0] <= 3'd3) |=> idx_q == '0); // R5
    AST_IDX_CEIL: assert property (@(posedge clk) disable iff (rst) idx_q <= idx_t'(STEP_COUNT - 1)); // R6
    AST_IDX_RISES: assert property (@(posedge clk) disable iff (rst) (stb_i && !clr_i && code_i[2:0] >= 3'd4) |=> (idx_q > $past(idx_q) || idx_q == idx_t'(STEP_COUNT - 1))); // R4
endmodule

bind adpcm_step_decoder adpcm_decoder_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .stb_i    (stb_i),
    .code_i   (code_i),
    .sample_o (sample_o),
    .valid_o  (valid_o),
    .idx_q    (idx_q)
);

// File: tb/sim_adpcm_step_decoder.sv
module sim_adpcm_step_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          stb = 1'b0;
    logic [3:0]    code = 4'd0;
    logic [SW-1:0] sample;
    logic          valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int tbl [49] = '{16, 17, 19, 21, 23, 25, 28, 31, 34, 37, 41, 45, 50, 55,
                     60, 66, 73, 80, 88, 97, 107, 118, 130, 143, 157, 173, 190,
                     209, 230, 253, 279, 307, 337, 371, 408, 449, 494, 544, 598,
                     658, 724, 796, 876, 963, 1060, 1166, 1282, 1411, 1552};
    int adj [8] = '{-1, -1, -1, -1, 2, 5, 7, 9};

    int m_acc = 0;
    int m_idx = 0;
    int m_vld = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adpcm_step_decoder #(.SAMPLE_W(SW)) u0 (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .stb_i    (stb),
        .code_i   (code),
        .sample_o (sample),
        .valid_o  (valid)
    );

    // behavioural reference
    always @(posedge clk) begin
        if (rst || clr) begin
            m_acc = 0; m_idx = 0; m_vld = 0;
        end else if (stb) begin
            int mag;
            int d;
            mag = code[2:0];
            d = ((2 * mag + 1) * tbl[m_idx]) / 8;
            m_acc = code[3] ? m_acc - d : m_acc + d;
            if (m_acc > 2047) m_acc = 2047;
            if (m_acc < -2048) m_acc = -2048;
            if (m_idx != 0 || mag > 3) m_idx = m_idx + adj[mag];
            if (m_idx > 48) m_idx = 48;
            if (m_idx < 0) m_idx = 0;
            m_vld = 1;
        end else begin
            m_vld = 0;
        end
    end

    function automatic int sx(input logic [SW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // per-clock comparison against the reference (R7 R8 R4)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 model sample", sx(sample), m_acc);
            chk("R8 model valid", int'(valid), m_vld);
        end
    end

    task automatic pulse(input logic [3:0] c);
        stb = 1'b1; code = c;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic do_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset sample", sx(sample), 0);
        chk("R10 reset valid", int'(valid), 0);
        rst = 1'b0;
        @(negedge clk);

        do_clr();
        pulse(4'h7);
        chk("R2 first delta", sx(sample), 30);
        chk("R8 valid pulse", int'(valid), 1);
        @(negedge clk);
        chk("R8 valid drops", int'(valid), 0);
        chk("R8 sample held", sx(sample), 30);
        pulse(4'hF);
        chk("R1 negative code", sx(sample), -39);
        chk("R3 step entry 9 used", sx(sample), 30 - (15 * 37) / 8);

        do_clr();
        chk("R9 clear zeroes", sx(sample), 0);
        pulse(4'h3); chk("R5 idx held 1", sx(sample), 14);
        pulse(4'h3); chk("R5 idx held 2", sx(sample), 28);
        pulse(4'h3); chk("R5 idx held 3", sx(sample), 42);

        do_clr();
        pulse(4'h4); chk("R4 old index used", sx(sample), 18);
        pulse(4'h0); chk("R4 new index next", sx(sample), 20);

        do_clr();
        repeat (12) pulse(4'h7);
        chk("R7 positive clamp", sx(sample), 2047);
        pulse(4'h8);
        chk("R6 index ceiling step", sx(sample), 2047 - 194);
        repeat (14) pulse(4'hF);
        chk("R7 negative clamp", sx(sample), -2048);

        clr = 1'b1; stb = 1'b1; code = 4'h7;
        @(negedge clk);
        clr = 1'b0; stb = 1'b0;
        chk("R9 clear beats strobe sample", sx(sample), 0);
        chk("R9 clear beats strobe valid", int'(valid), 0);
        pulse(4'h7);
        chk("R9 index cleared", sx(sample), 30);

        for (int i = 0; i < 3000; i++) begin
            stb  = ($urandom_range(0, 3) != 0);
            clr  = ($urandom_range(0, 199) == 0);
            code = 4'($urandom_range(0, 15));
            @(negedge clk);
        end
        stb = 1'b0; clr = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule